// File: doc/BRIEF.md
# Level-Sensitive GPIO Interrupt Controller

This block is a bank of general-purpose pins with interrupt generation, controlled through a simple 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. Software chooses, one bit per pin, whether each pin is driven or sampled. It sets the value of the output latch and reads back the pin state. It also picks the level, high or low, at which each pin raises an interrupt request.

Every pin input passes through a two-flop synchroniser before it is used. While a synchronised pin sits at its selected level, that pin's status bit is held set. Software acknowledges a status bit by writing a zero to that bit position; bits written as one are left alone. The status bits can be read a second time through a read-only pending view. A separate mask register gates them, and the surviving bits are ORed onto one interrupt line toward a parent controller. Every interrupt comes out of reset masked.

The address map has two groups. The pin group uses offsets 0x00 to 0x0C. The interrupt group uses 0x10 for pending and 0x18 for mask.

Top module: `lvl_gpio_irq_ctrl`

## Requirements
- R1: After reset the direction register, output latch and level register are all zeros, the status bits are zero, the mask register is all ones, and `irq_out` is low.
- R2: The direction register is at offset 0x00. A direction bit of 1 makes the pin an output: `pin_oe` bit is 1 and `pin_out` carries the output latch bit. The output latch is written through offset 0x04 regardless of direction.
- R3: A read of offset 0x04 returns, per bit, the output latch when the direction bit is 1 and the synchronised pin value when it is 0.
- R4: A change on `pin_in` is visible in the offset 0x04 read after exactly two rising clock edges, and not after one.
- R5: The level register is at offset 0x08. A status bit (offset 0x0C) becomes 1 on the clock edge after the synchronised pin equals its level bit: level 1 means active while high, level 0 means active while low.
- R6: A write to offset 0x0C clears every status bit written as 0 and leaves every status bit written as 1 unchanged.
- R7: If a pin is still at its active level when its status bit is acknowledged, the bit reads 1 again right after the acknowledging write.
- R8: Offset 0x10 reads the status bits and ignores writes.
- R9: The mask register is at offset 0x18, and a mask bit of 1 disables that pin. `irq_out` is the OR of all status bits whose mask bit is 0.
- R10: Any other offset (for example 0x01, 0x14 or 0x1C) reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Output latch value toward the pads |
| pin_oe | output | NUM_PINS | Output enable per pin (direction register) |
| irq_out | output | 1 | Interrupt request to the parent controller |

## Verification
A wrong status bit shows at the pending and status reads one edge after the pin's synchronised value changes. The same bit shows on `irq_out` as soon as it is unmasked, so a walking sweep of each pin in turn under both levels exposes it within three cycles of the pin change. A fault in the acknowledge path shows as a status bit that survives a zero write after the pin has gone inactive, or that fails to reappear while the pin stays active. A synchroniser of the wrong depth shows as data read back one edge early or late. Errors in the mask or the address decode show at once on `irq_out`, `pin_oe`, `pin_out` and the unmapped-offset reads.

// File: rtl/lgi_pkg.sv
package lgi_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 5;

  // pin group
  localparam logic [ADDR_W-1:0] OFS_DIR   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_LEVEL = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h0C;
  // interrupt group
  localparam logic [ADDR_W-1:0] OFS_PEND  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 5'h18;

  typedef struct packed {
    logic dir;
    logic data;
    logic level;
    logic stat;
    logic pend;
    logic mask;
  } reg_sel_t;

  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] addr);
    reg_sel_t s;
    s       = '0;
    s.dir   = (addr == OFS_DIR);
    s.data  = (addr == OFS_DATA);
    s.level = (addr == OFS_LEVEL);
    s.stat  = (addr == OFS_STAT);
    s.pend  = (addr == OFS_PEND);
    s.mask  = (addr == OFS_MASK);
    return s;
  endfunction
endpackage

// File: rtl/lgi_sync.sv
module lgi_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = async_in;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        stage_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < STAGES; s++) begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/lgi_regfile.sv
module lgi_regfile
  import lgi_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  reg_sel_t            sel,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] out_q,
  output logic [NUM_PINS-1:0] level_q,
  output logic [NUM_PINS-1:0] mask_q
);
  logic dir_en, out_en, level_en, mask_en;
  logic [NUM_PINS-1:0] dir_d, out_d, level_d, mask_d;

  always_comb begin
    dir_en   = wr_en && sel.dir;
    out_en   = wr_en && sel.data;
    level_en = wr_en && sel.level;
    mask_en  = wr_en && sel.mask;
    dir_d    = dir_en   ? wdata : dir_q;
    out_d    = out_en   ? wdata : out_q;
    level_d  = level_en ? wdata : level_q;
    mask_d   = mask_en  ? wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      level_q <= '0;
      mask_q  <= '1;
    end else begin
      dir_q   <= dir_d;
      out_q   <= out_d;
      level_q <= level_d;
      mask_q  <= mask_d;
    end
  end
endmodule

// File: rtl/lgi_irq_status.sv
module lgi_irq_status #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_sync,
  input  logic [NUM_PINS-1:0] level_q,
  input  logic [NUM_PINS-1:0] mask_q,
  input  logic                ack_wr,
  input  logic [NUM_PINS-1:0] ack_data,
  output logic [NUM_PINS-1:0] status_q,
  output logic                irq
);
  logic [NUM_PINS-1:0] hit;
  logic [NUM_PINS-1:0] keep;
  logic [NUM_PINS-1:0] status_d;

  always_comb begin
    hit      = ~(pin_sync ^ level_q);
    keep     = ack_wr ? ack_data : '1;
    status_d = (status_q & keep) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else begin
      status_q <= status_d;
    end
  end

  assign irq = |(status_q & ~mask_q);
endmodule

// File: rtl/lgi_rdmux.sv
module lgi_rdmux
  import lgi_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  reg_sel_t            sel,
  input  logic [NUM_PINS-1:0] dir_q,
  input  logic [NUM_PINS-1:0] out_q,
  input  logic [NUM_PINS-1:0] pin_sync,
  input  logic [NUM_PINS-1:0] level_q,
  input  logic [NUM_PINS-1:0] status_q,
  input  logic [NUM_PINS-1:0] mask_q,
  output logic [REG_W-1:0]    rdata
);
  logic [NUM_PINS-1:0] data_view;
  logic [NUM_PINS-1:0] picked;

  always_comb begin
    data_view = (dir_q & out_q) | (~dir_q & pin_sync);
    picked    = '0;
    if (sel.dir)   picked = dir_q;
    if (sel.data)  picked = data_view;
    if (sel.level) picked = level_q;
    if (sel.stat)  picked = status_q;
    if (sel.pend)  picked = status_q;
    if (sel.mask)  picked = mask_q;
    rdata = REG_W'(picked);
  end
endmodule

// File: rtl/lvl_gpio_irq_ctrl.sv
module lvl_gpio_irq_ctrl
  import lgi_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_out
);
  logic [1:0]          rst_pipe_q;
  logic                rst_n_sync;
  reg_sel_t            sel;
  logic [NUM_PINS-1:0] wdata_pins;
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] dir_q, out_q, level_q, mask_q, status_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_sync = rst_pipe_q[1];

  assign sel        = decode_addr(reg_addr);
  assign wdata_pins = reg_wdata[NUM_PINS-1:0];

  lgi_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n_sync), .async_in(pin_in), .sync_out(pin_sync)
  );

  lgi_regfile #(.NUM_PINS(NUM_PINS)) regs_i (
    .clk(clk), .rst_n(rst_n_sync), .wr_en(reg_wr), .sel(sel),
    .wdata(wdata_pins), .dir_q(dir_q), .out_q(out_q),
    .level_q(level_q), .mask_q(mask_q)
  );

  lgi_irq_status #(.NUM_PINS(NUM_PINS)) stat_i (
    .clk(clk), .rst_n(rst_n_sync), .pin_sync(pin_sync), .level_q(level_q),
    .mask_q(mask_q), .ack_wr(reg_wr && sel.stat), .ack_data(wdata_pins),
    .status_q(status_q), .irq(irq_out)
  );

  lgi_rdmux #(.NUM_PINS(NUM_PINS)) rd_i (
    .sel(sel), .dir_q(dir_q), .out_q(out_q), .pin_sync(pin_sync),
    .level_q(level_q), .status_q(status_q), .mask_q(mask_q),
    .rdata(reg_rdata)
  );

  assign pin_oe  = dir_q;
  assign pin_out = out_q;
endmodule

// File: rtl/lgi_checker.sv
module lgi_checker
  import lgi_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_n_sync,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic                reg_wr,
  input logic [REG_W-1:0]    reg_wdata,
  input logic [REG_W-1:0]    reg_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq_out,
  input logic [NUM_PINS-1:0] pin_sync,
  input logic [NUM_PINS-1:0] level_q,
  input logic [NUM_PINS-1:0] status_q,
  input logic [NUM_PINS-1:0] mask_q
);
  logic unmapped;
  assign unmapped = (reg_addr != 5'h00) && (reg_addr != 5'h04) &&
                    (reg_addr != 5'h08) && (reg_addr != 5'h0C) &&
                    (reg_addr != 5'h10) && (reg_addr != 5'h18);

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (reg_wr && reg_addr == 5'h00) |=> (pin_oe == $past(reg_wdata[NUM_PINS-1:0])));

  // R5
  status_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ((status_q & ~$past(status_q)) & ($past(pin_sync) ^ $past(level_q))) == '0);

  // R6
  ack_keep_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (reg_wr && reg_addr == 5'h0C) |=>
      ((status_q & $past(reg_wdata[NUM_PINS-1:0] & status_q)) ==
       $past(reg_wdata[NUM_PINS-1:0] & status_q)));

  // R8
  pending_view_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (reg_addr == 5'h10) |-> (reg_rdata == REG_W'(status_q)));

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mask_q == '1) |-> !irq_out);

  // R10
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (reg_wr && unmapped) |=> ($stable(pin_oe) && $stable(pin_out) && $stable(mask_q)));

  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    unmapped |-> (reg_rdata == '0));
endmodule

bind lvl_gpio_irq_ctrl lgi_checker #(.NUM_PINS(NUM_PINS)) chk_i (.*);

// File: tb/lvl_gpio_irq_ctrl_tb_top.sv
module lvl_gpio_irq_ctrl_tb_top;
  localparam int unsigned NP = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [4:0]    reg_addr;
  logic          reg_wr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] pin_in;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic          irq_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lvl_gpio_irq_ctrl #(.NUM_PINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; pin_in = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state (internal reset release still in progress)
    rd(5'h00, v); chk("R1 dir", v, 32'h0);
    rd(5'h08, v); chk("R1 level", v, 32'h0);
    rd(5'h18, v); chk("R1 mask", v, 32'hFFFF_FFFF);
    rd(5'h0C, v); chk("R1 status", v, 32'h0);
    chk("R1 irq", {31'b0, irq_out}, 32'h0);
    chk("R1 oe", pin_oe, 32'h0);
    chk("R1 out", pin_out, 32'h0);
    cyc(6);
    // R5 low level: all pins low, level 0
    rd(5'h0C, v); chk("R5 low-level status", v, 32'hFFFF_FFFF);

    // R5/R6/R7/R9 walking sweep with level high
    wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h0C, 32'h0);
    rd(5'h0C, v); chk("R6 clear all", v, 32'h0);
    for (int i = 0; i < NP; i++) begin
      logic [31:0] b;
      b = 32'h1 << i;
      pin_in = b;
      cyc(2);
      rd(5'h0C, v); chk("R5 not yet", v, 32'h0);
      cyc(1);
      rd(5'h0C, v); chk("R5 set", v, b);
      rd(5'h10, v); chk("R8 pending", v, b);
      chk("R9 masked", {31'b0, irq_out}, 32'h0);
      wr(5'h18, ~b);
      chk("R9 unmasked", {31'b0, irq_out}, 32'h1);
      wr(5'h18, ~(32'h1 << ((i + 1) % NP)));
      chk("R9 other unmasked", {31'b0, irq_out}, 32'h0);
      wr(5'h18, 32'hFFFF_FFFF);
      wr(5'h0C, ~b);
      rd(5'h0C, v); chk("R7 re-set", v, b);
      pin_in = '0;
      cyc(3);
      wr(5'h0C, ~b);
      rd(5'h0C, v); chk("R6 ack", v, 32'h0);
    end

    // R6 partial acknowledge
    pin_in = 32'hA5A5_0F0F;
    cyc(3);
    pin_in = '0;
    cyc(3);
    rd(5'h0C, v); chk("R5 pattern", v, 32'hA5A5_0F0F);
    wr(5'h0C, ~32'h0000_0F00);
    rd(5'h0C, v); chk("R6 partial", v, 32'hA5A5_000F);

    // R8 write to pending ignored
    wr(5'h10, 32'h0);
    rd(5'h0C, v); chk("R8 write ignored", v, 32'hA5A5_000F);

    // R2/R3 direction and data sweep
    for (int k = 1; k <= 8; k++) begin
      logic [31:0] p, q, r;
      p = k * 32'h9E37_79B9;
      q = (k * 32'h7F4A_7C15) ^ 32'h0F0F_F0F0;
      r = ~p ^ (k << 3);
      wr(5'h00, p);
      wr(5'h04, q);
      pin_in = r;
      cyc(2);
      chk("R2 oe", pin_oe, p);
      chk("R2 out", pin_out, q);
      rd(5'h04, v); chk("R3 data mix", v, (p & q) | (~p & r));
    end

    // R4 synchroniser depth
    wr(5'h00, 32'h0);
    pin_in = '0;
    cyc(3);
    pin_in = 32'hC3C3_5A5A;
    cyc(1);
    rd(5'h04, v); chk("R4 one edge", v, 32'h0);
    cyc(1);
    rd(5'h04, v); chk("R4 two edges", v, 32'hC3C3_5A5A);

    // R10 unmapped offsets
    wr(5'h00, 32'h1234_5678);
    wr(5'h04, 32'h8765_4321);
    wr(5'h08, 32'h00FF_00FF);
    wr(5'h18, 32'hF0F0_F0F0);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h1C, 32'h0);
    wr(5'h01, 32'hAAAA_AAAA);
    chk("R10 oe", pin_oe, 32'h1234_5678);
    chk("R10 out", pin_out, 32'h8765_4321);
    rd(5'h08, v); chk("R10 level", v, 32'h00FF_00FF);
    rd(5'h18, v); chk("R10 mask", v, 32'hF0F0_F0F0);
    rd(5'h14, v); chk("R10 read 14", v, 32'h0);
    rd(5'h1C, v); chk("R10 read 1C", v, 32'h0);
    rd(5'h01, v); chk("R10 read 01", v, 32'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule